// File: doc/BRIEF.md
# Forwarded-Clock Serial Word Transmitter

This block moves one fixed-width parallel word per frame to an external receiver over three outgoing lines: a serial clock, an active-low frame select and a data line. It also captures a word from a return data line during the same frame. Everything runs from one internal clock at twice the bit rate. The serial clock is a register that toggles on that fast clock, so every serial clock edge falls on a fast-clock edge. Outgoing data moves only on the serial clock edges where the receiver is not sampling. The capture edge and the next data change are therefore always one fast period apart. No edge-mixed logic and no delay tuning is needed for this.

The user presents a word together with a load strobe while `ready_o` is high. The block latches the word and the two mode inputs, clock polarity and clock phase. It then opens the frame and emits the bits most significant first. After the frame closes it pulses `done_o` for one cycle, and the captured return word appears on `rx_word_o`.

Top module: `fwd_serial_tx`

## Requirements
- R1: While `rst_ni` is low, `sel_n_o` is 1, `sdo_o` is 0, `sclk_o` is 0, `done_o` is 0 and `ready_o` is 1.
- R2: A cycle with `load_i` and `ready_o` both high accepts `word_i`. `sel_n_o` goes to 0 and `ready_o` goes to 0 on that clock edge. `sclk_o` holds its idle level for the next fast cycle, so at least one fast cycle lies between frame assertion and the first serial clock edge.
- R3: Each frame carries exactly 2×WIDTH serial clock transitions. Each transition is one fast cycle after the previous one, so one serial bit lasts two fast cycles.
- R4: The capture edge is the serial clock transition whose new level XOR `cpol` XOR `cpha` equals 1. This is a rising edge when cpol equals cpha, and a falling edge otherwise. `sdo_o` never changes on a capture edge, and it only changes on the transitions between capture edges.
- R5: A receiver that samples `sdo_o` on the capture edges gets the accepted word, MSB first, in all four mode combinations. When cpha is 0, the MSB is already on `sdo_o` when the frame opens.
- R6: On each capture edge the block samples `sdi_i` into a shift register, MSB first. The full WIDTH-bit return word appears on `rx_word_o` when the frame closes, and it holds until the next frame closes.
- R7: `sel_n_o` returns to 1 exactly one fast cycle after the last serial clock transition, which is 2×WIDTH+1 cycles after acceptance. `done_o` is high for exactly that one cycle after the release.
- R8: While `sel_n_o` is 1, `sdo_o` is 0 and `sclk_o` equals the `cpol_i` value of the previous cycle.
- R9: Changes on `cpol_i`, `cpha_i`, `word_i` and `load_i` during an open frame have no effect on the serial lines, the edge count or the returned word. Mode and word are taken only at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| load_i | input | 1 | Word valid strobe |
| word_i | input | WIDTH | Parallel word to send |
| ready_o | output | 1 | Block idle, a load is accepted |
| sclk_o | output | 1 | Forwarded serial clock |
| sel_n_o | output | 1 | Frame select, active low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial return data in |
| done_o | output | 1 | One-cycle pulse at frame close |
| rx_word_o | output | WIDTH | Last captured return word |

## Verification
The assertions assume that `cpol_i` does not change during the cycle before acceptance. The setup-gap and idle-level properties compare the serial clock against that input, so they depend on this. They also assume that `sdi_i` changes only after the block's launch edges, the way a well-behaved receiver drives it. The stimulus sets the mode two cycles before each load and only scrambles the mode, word and load inputs while a frame is open. The bench's receiver model drives the return line one half-cycle after each launch edge it sees, so the return data never changes near a capture edge.

// File: rtl/fwd_serial_tx_pkg.sv
package fwd_serial_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } tx_state_e;
endpackage

// File: rtl/fst_sclk_gen.sv
module fst_sclk_gen #(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic run_i,
  input  logic pol_i,
  input  logic pha_i,
  output logic sclk_o,
  output logic launch_o,
  output logic capture_o,
  output logic last_o
);
  localparam int HALVES = 2 * WIDTH;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] HLAST = HW'(HALVES - 1);

  logic [HW-1:0] hcnt_q;
  logic          sclk_q;
  logic          lead;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      hcnt_q <= '0;
    end else if (run_i) begin
      sclk_q <= ~sclk_q;
      hcnt_q <= (hcnt_q == HLAST) ? '0 : hcnt_q + 1'b1;
    end else if (idle_i) begin
      sclk_q <= pol_i;
      hcnt_q <= '0;
    end
  end

  // even half index = leading edge of a bit
  assign lead      = ~hcnt_q[0];
  assign launch_o  = run_i & (pha_i ? lead : ~lead);
  assign capture_o = run_i & (pha_i ? ~lead : lead);
  assign last_o    = run_i & (hcnt_q == HLAST);
  assign sclk_o    = sclk_q;
endmodule

// File: rtl/fst_shift_out.sv
module fst_shift_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pha_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             launch_i,
  input  logic             clear_i,
  output logic             sdo_o
);
  logic [WIDTH-1:0] sh_q;
  logic             sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (start_i) begin
      // phase 0 presents the MSB before the first edge
      sh_q  <= pha_i ? word_i : {word_i[WIDTH-2:0], 1'b0};
      sdo_q <= pha_i ? 1'b0 : word_i[WIDTH-1];
    end else if (clear_i) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (launch_i) begin
      sh_q  <= {sh_q[WIDTH-2:0], 1'b0};
      sdo_q <= sh_q[WIDTH-1];
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/fst_shift_in.sv
module fst_shift_in #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             capture_i,
  input  logic             sdi_i,
  input  logic             finish_i,
  output logic [WIDTH-1:0] rx_word_o
);
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      out_q <= '0;
    end else begin
      if (start_i)        acc_q <= '0;
      else if (capture_i) acc_q <= {acc_q[WIDTH-2:0], sdi_i};
      if (finish_i)       out_q <= acc_q;
    end
  end

  assign rx_word_o = out_q;
endmodule

// File: rtl/fwd_serial_tx.sv
module fwd_serial_tx
  import fwd_serial_tx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             ready_o,
  output logic             sclk_o,
  output logic             sel_n_o,
  output logic             sdo_o,
  input  logic             sdi_i,
  output logic             done_o,
  output logic [WIDTH-1:0] rx_word_o
);
  tx_state_e state_q;
  logic      accept, run, idle, tail, last;
  logic      launch, capture;
  logic      mode_pol_q, mode_pha_q;
  logic      sel_n_q, done_q;

  assign idle   = (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);
  assign tail   = (state_q == ST_TAIL);
  assign accept = idle & load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sel_n_q    <= 1'b1;
      done_q     <= 1'b0;
      mode_pol_q <= 1'b0;
      mode_pha_q <= 1'b0;
    end else begin
      done_q <= tail;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_RUN;
          sel_n_q    <= 1'b0;
          mode_pol_q <= cpol_i;
          mode_pha_q <= cpha_i;
        end
        ST_RUN:  if (last) state_q <= ST_TAIL;
        ST_TAIL: begin
          state_q <= ST_IDLE;
          sel_n_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fst_sclk_gen #(.WIDTH(WIDTH)) u_sclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (idle),
    .run_i     (run),
    .pol_i     (cpol_i),
    .pha_i     (mode_pha_q),
    .sclk_o    (sclk_o),
    .launch_o  (launch),
    .capture_o (capture),
    .last_o    (last)
  );

  fst_shift_out #(.WIDTH(WIDTH)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .pha_i    (cpha_i),
    .word_i   (word_i),
    .launch_i (launch),
    .clear_i  (tail),
    .sdo_o    (sdo_o)
  );

  fst_shift_in #(.WIDTH(WIDTH)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .capture_i (capture),
    .sdi_i     (sdi_i),
    .finish_i  (tail),
    .rx_word_o (rx_word_o)
  );

  assign ready_o = idle;
  assign sel_n_o = sel_n_q;
  assign done_o  = done_q;
endmodule

// File: rtl/fwd_serial_tx_chk.sv
module fwd_serial_tx_chk #(
  parameter int WIDTH = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic ready_o,
  input logic sclk_o,
  input logic sel_n_o,
  input logic sdo_o,
  input logic done_o,
  input logic pol_q,
  input logic pha_q
);
  localparam int CW = $clog2(2 * WIDTH + 2) + 1;

  logic [CW-1:0] edge_cnt;
  logic          sclk_prev;
  logic [1:0]    arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt  <= '0;
      sclk_prev <= 1'b0;
      arm       <= '0;
    end else begin
      sclk_prev <= sclk_o;
      if (arm != 2'd3) arm <= arm + 1'b1;
      if (sel_n_o)                edge_cnt <= '0;
      else if (sclk_o != sclk_prev) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_n_o |-> !ready_o); // R2
  AST_SETUP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm == 2'd3 && $fell(sel_n_o)) |-> $stable(sclk_o)); // R2
  AST_EDGE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm == 2'd3 && $rose(sel_n_o)) |-> edge_cnt == CW'(2 * WIDTH)); // R3
  AST_NO_DATA_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_o && $past(!sel_n_o) && !$stable(sclk_o) && (sclk_o ^ pol_q ^ pha_q))
      |-> $stable(sdo_o)); // R4
  AST_RELEASE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm == 2'd3 && $rose(sel_n_o)) |-> ($stable(sclk_o) && done_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_IDLE_DATA_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_o |-> !sdo_o); // R8
  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm == 2'd3 && sel_n_o && $past(sel_n_o)) |-> sclk_o == $past(cpol_i)); // R8
endmodule

bind fwd_serial_tx fwd_serial_tx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cpol_i  (cpol_i),
  .ready_o (ready_o),
  .sclk_o  (sclk_o),
  .sel_n_o (sel_n_o),
  .sdo_o   (sdo_o),
  .done_o  (done_o),
  .pol_q   (mode_pol_q),
  .pha_q   (mode_pha_q)
);

// File: tb/fwd_serial_tx_test.sv
module fwd_serial_tx_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpol = 1'b0, cpha = 1'b0, load = 1'b0, sdi = 1'b0;
  logic [W-1:0] word = '0;
  logic         ready, sclk, sel_n, sdo, done;
  logic [W-1:0] rx_word;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fwd_serial_tx #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha),
    .load_i(load), .word_i(word), .ready_o(ready), .sclk_o(sclk),
    .sel_n_o(sel_n), .sdo_o(sdo), .sdi_i(sdi), .done_o(done),
    .rx_word_o(rx_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // capture edge per R4: new level ^ cpol ^ cpha == 1
  function automatic bit is_capture(input bit lvl, input bit pol, input bit pha);
    return lvl ^ pol ^ pha;
  endfunction

  function automatic int frame_cycles();
    return 2 * W + 1;
  endfunction

  task automatic xfer(input logic [W-1:0] w, input logic [W-1:0] rep,
                      input bit pol, input bit pha, input bit noisy);
    logic [W-1:0] seen = '0;
    bit prev_sclk, prev_sdo, launched;
    int edges = 0, launches = 0, cyc = 0, bad_data = 0, bad_cap = 0;
    @(negedge clk);
    cpol = pol; cpha = pha; load = 1'b0;
    sdi  = pha ? 1'b0 : rep[W-1];
    @(negedge clk); @(negedge clk);
    chk(sclk == pol && sdo == 1'b0 && sel_n, "R8 idle lines", {sclk, sdo, sel_n}, {pol, 1'b0, 1'b1});
    chk(ready == 1'b1, "R2 ready before load", ready, 1);
    word = w; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(sel_n == 1'b0 && ready == 1'b0, "R2 frame opened", {sel_n, ready}, 2'b00);
    chk(sclk == pol, "R2 setup gap", sclk, pol);
    prev_sclk = sclk; prev_sdo = sdo;
    while (sel_n == 1'b0 && cyc < 4 * W + 10) begin
      @(negedge clk);
      cyc++;
      if (sel_n) break;
      launched = 1'b0;
      if (sclk != prev_sclk) begin
        edges++;
        if (is_capture(sclk, pol, pha)) begin
          if (sdo != prev_sdo) bad_cap++;
          seen = {seen[W-2:0], sdo};
        end else begin
          launched = 1'b1;
          launches++;
          begin
            int idx = pha ? launches - 1 : launches;
            if (idx < W) sdi = rep[W-1-idx];
          end
        end
      end
      if (!launched && sclk == prev_sclk && sdo != prev_sdo) bad_data++;
      prev_sclk = sclk; prev_sdo = sdo;
      if (noisy) begin
        cpol = 1'($urandom); cpha = 1'($urandom);
        load = 1'($urandom); word = W'($urandom);
      end
    end
    cpol = pol; cpha = pha; load = 1'b0;
    chk(bad_cap == 0, "R4 data stable on capture edges", bad_cap, 0);
    chk(bad_data == 0, "R4 data moves only on launch edges", bad_data, 0);
    chk(edges == 2 * W, noisy ? "R3 edge count under R9 noise" : "R3 edge count", edges, 2 * W);
    chk(seen == w, noisy ? "R5 word received, R9 noise" : "R5 word received", seen, w);
    chk(cyc == frame_cycles(), "R7 release timing", cyc, frame_cycles());
    chk(done == 1'b1, "R7 done at release", done, 1);
    chk(rx_word == rep, "R6 return word", rx_word, rep);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    @(negedge clk);
    chk(sclk == pol && sdo == 1'b0, "R8 idle after frame", {sclk, sdo}, {pol, 1'b0});
    chk(rx_word == rep, "R6 return word held", rx_word, rep);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    chk(sel_n == 1'b1 && sdo == 1'b0 && sclk == 1'b0, "R1 reset lines", {sel_n, sdo, sclk}, 3'b100);
    chk(done == 1'b0 && ready == 1'b1, "R1 reset flags", {done, ready}, 2'b01);
    rst_n = 1'b1;
    // directed corners: all modes, edge patterns
    xfer(8'h80, 8'h01, 1'b0, 1'b0, 1'b0);
    xfer(8'h01, 8'h80, 1'b0, 1'b1, 1'b0);
    xfer(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
    xfer(8'h00, 8'hFF, 1'b1, 1'b1, 1'b0);
    xfer(8'hA5, 8'h5A, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 24; i++)
      xfer(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom), 1'(i % 2));
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=hung expected=frames complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule